// File: doc/BRIEF.md
# Stereo Sample Delay Line

This block holds back a stereo audio stream by a whole number of sample periods. A sample strobe carries a left word and a right word into the block together. One clock cycle after each strobe, the block presents the pair that entered the configured number of strobes earlier. Both channels share one delay value, so they leave the block as aligned as they entered it.

The active delay comes from one of two sources, and a mode input picks between them. The first is a direct 12-bit sample count. The second is a count supplied by an external frame-based delay calculator. That count may be wider than 12 bits, and the block limits it to the largest delay it can hold.

Internally the block keeps a circular buffer of past sample pairs and a wrapping write pointer. The read position is the write pointer minus the delay. A delay of zero bypasses the buffer entirely. Buffer positions that have not been written since reset read as silence.

Top module: `stereo_delay_line`

## Requirements
- R1: With an active delay of 0, the output pair shown after a strobe equals the pair presented on that same strobe.
- R2: With an active delay of N, the output pair shown after strobe k equals the input pair of strobe k-N, where strobes are counted from reset.
- R3: The direct delay input is an unsigned 12-bit count covering 0 to 4095. A delay of 4095 is honoured exactly.
- R4: When frame_mode is 1, direct_delay has no effect and the frame-based count sets the delay. When frame_mode is 0, frame_delay has no effect.
- R5: A frame-based count above 4095 is treated as 4095.
- R6: Left and right use the same delay. The left output always comes from the left input and the right output from the right input of the same earlier strobe.
- R7: If the active delay exceeds the number of strobes since reset, both outputs are zero, even when the buffer still holds data from before the reset.
- R8: Delay settings are sampled only on a strobe, and a change applies from the next strobe. out_vld is 1 in exactly the cycle after each strobe. Between strobes the output words hold their values, whatever the delay inputs do.
- R9: During and right after reset, out_vld, out_left and out_right are 0.
- R10: The write position wraps around the 4096-entry buffer, and the delay stays exact across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Sample strobe, one cycle per stereo pair |
| in_left | input | SAMPLE_W | Left input word |
| in_right | input | SAMPLE_W | Right input word |
| frame_mode | input | 1 | 0: use direct_delay, 1: use frame_delay |
| direct_delay | input | ADDR_W | Direct delay in samples |
| frame_delay | input | FRAME_W | Frame-based delay count from an external calculator |
| out_vld | output | 1 | High in the cycle after each strobe |
| out_left | output | SAMPLE_W | Delayed left word, held between strobes |
| out_right | output | SAMPLE_W | Delayed right word, held between strobes |

## Verification
The delay is driven with zero, small direct counts, a decrease, and frame-based counts, while direct_delay is set to a different value. This separates bypass errors from off-by-one read positions and shows which delay source is actually in use. Each channel carries its own ramp, so a swapped or misaligned channel stands out. After a mid-run reset, the maximum delay of 4095 is run across more than one full buffer wrap: the first 4095 outputs must be silent despite stale buffer contents, and the later outputs must match exactly. Oversized frame counts then check the clamp, and delay changes between strobes confirm that held outputs do not move.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic {
    SRC_DIRECT = 1'b0,
    SRC_FRAME  = 1'b1
  } delay_src_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_BYP  = 2'd1,
    SEL_RAM  = 2'd2
  } out_sel_e;

endpackage

// File: rtl/sdl_rst_sync.sv
module sdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/sdl_delay_sel.sv
module sdl_delay_sel
  import sdl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int FRAME_W = 16
) (
  input  delay_src_e          src,
  input  logic [ADDR_W-1:0]   direct_cnt,
  input  logic [FRAME_W-1:0]  frame_cnt,
  output logic [ADDR_W-1:0]   act_delay
);
  localparam logic [FRAME_W-1:0] LIMIT = FRAME_W'((64'd1 << ADDR_W) - 64'd1);

  logic [ADDR_W-1:0] frame_lim;

  always_comb begin
    if (frame_cnt > LIMIT) frame_lim = '1;
    else                   frame_lim = frame_cnt[ADDR_W-1:0];
  end

  always_comb begin
    case (src)
      SRC_FRAME: act_delay = frame_lim;
      default:   act_delay = direct_cnt;
    endcase
  end
endmodule

// File: rtl/sdl_fill_track.sv
module sdl_fill_track #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W:0]   fill
);
  localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W-1:0] wptr_d;
  logic [ADDR_W:0]   fill_d;

  always_comb begin
    wptr_d = wptr;
    fill_d = fill;
    if (adv) begin
      wptr_d = wptr + 1'b1;
      if (fill != FULL) fill_d = fill + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else begin
      wptr <= wptr_d;
      fill <= fill_d;
    end
  end
endmodule

// File: rtl/sdl_ring_ram.sv
module sdl_ring_ram #(
  parameter int DATA_W = 48,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line
  import sdl_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 12,
  parameter int FRAME_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                frame_mode,
  input  logic [ADDR_W-1:0]   direct_delay,
  input  logic [FRAME_W-1:0]  frame_delay,
  output logic                out_vld,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int PAIR_W = 2 * SAMPLE_W;

  logic              rst_q;
  logic [ADDR_W-1:0] act_delay;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W:0]   fill;
  logic [ADDR_W-1:0] raddr;
  logic [PAIR_W-1:0] in_pair;
  logic [PAIR_W-1:0] ram_rdata;
  logic              unwritten;
  delay_src_e        src;

  out_sel_e          sel_q, sel_d;
  logic [PAIR_W-1:0] byp_q, byp_d;
  logic              vld_q, vld_d;
  logic [PAIR_W-1:0] out_pair;

  sdl_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign src = frame_mode ? SRC_FRAME : SRC_DIRECT;

  sdl_delay_sel #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_sel (
    .src        (src),
    .direct_cnt (direct_delay),
    .frame_cnt  (frame_delay),
    .act_delay  (act_delay)
  );

  sdl_fill_track #(.ADDR_W(ADDR_W)) u_track (
    .clk   (clk),
    .rst_n (rst_q),
    .adv   (in_vld),
    .wptr  (wptr),
    .fill  (fill)
  );

  assign in_pair   = {in_left, in_right};
  assign raddr     = wptr - act_delay;
  assign unwritten = ({1'b0, act_delay} > fill);

  sdl_ring_ram #(.DATA_W(PAIR_W), .ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (in_vld),
    .waddr (wptr),
    .wdata (in_pair),
    .re    (in_vld),
    .raddr (raddr),
    .rdata (ram_rdata)
  );

  always_comb begin
    sel_d = sel_q;
    byp_d = byp_q;
    vld_d = in_vld;
    if (in_vld) begin
      if (act_delay == '0) begin
        sel_d = SEL_BYP;
        byp_d = in_pair;
      end else if (unwritten) begin
        sel_d = SEL_ZERO;
      end else begin
        sel_d = SEL_RAM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q <= SEL_ZERO;
      byp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      byp_q <= byp_d;
      vld_q <= vld_d;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_BYP: out_pair = byp_q;
      SEL_RAM: out_pair = ram_rdata;
      default: out_pair = '0;
    endcase
  end

  assign out_vld   = vld_q;
  assign out_left  = out_pair[PAIR_W-1:SAMPLE_W];
  assign out_right = out_pair[SAMPLE_W-1:0];
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int SAMPLE_W = 24,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_q,
  input logic                in_vld,
  input logic [SAMPLE_W-1:0] in_left,
  input logic [SAMPLE_W-1:0] in_right,
  input logic [ADDR_W-1:0]   act_delay,
  input logic [ADDR_W-1:0]   wptr,
  input logic [ADDR_W:0]     fill,
  input logic                out_vld,
  input logic [SAMPLE_W-1:0] out_left,
  input logic [SAMPLE_W-1:0] out_right
);

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && act_delay == '0) |=> (out_left == $past(in_left) && out_right == $past(in_right)));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (in_vld && ({1'b0, act_delay} > fill)) |=> (out_left == '0 && out_right == '0));

  assert_strobe_vld_R8: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> out_vld);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |=> (!out_vld && $stable(out_left) && $stable(out_right)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> (wptr == $past(wptr) + 1'b1));

endmodule

bind stereo_delay_line sdl_checker #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_q     (rst_q),
  .in_vld    (in_vld),
  .in_left   (in_left),
  .in_right  (in_right),
  .act_delay (act_delay),
  .wptr      (wptr),
  .fill      (fill),
  .out_vld   (out_vld),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/stereo_delay_line_tb_top.sv
`timescale 1ns/1ps
module stereo_delay_line_tb_top;
  localparam int SW    = 24;
  localparam int AW    = 12;
  localparam int FW    = 16;
  localparam int DEPTH = 4096;
  localparam int MAXD  = 4095;

  typedef struct packed {
    logic        mode;
    logic [11:0] direct;
    logic [15:0] frame;
    logic [7:0]  cnt;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{1'b0, 12'd0, 16'd9,   8'd6},
    '{1'b0, 12'd1, 16'd9,   8'd6},
    '{1'b0, 12'd5, 16'd0,   8'd10},
    '{1'b0, 12'd3, 16'd0,   8'd6},
    '{1'b1, 12'd5, 16'd2,   8'd8},
    '{1'b1, 12'd0, 16'd7,   8'd8},
    '{1'b0, 12'd7, 16'd11,  8'd8},
    '{1'b1, 12'd9, 16'd0,   8'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_vld;
  logic [SW-1:0] in_left, in_right;
  logic          frame_mode;
  logic [AW-1:0] direct_delay;
  logic [FW-1:0] frame_delay;
  logic          out_vld;
  logic [SW-1:0] out_left, out_right;

  int n_cmp = 0;
  int n_bad = 0;
  int k     = 0;
  int seq   = 0;
  logic [2*SW-1:0] hist [DEPTH];

  always #4 clk = ~clk;

  stereo_delay_line #(.SAMPLE_W(SW), .ADDR_W(AW), .FRAME_W(FW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .in_left      (in_left),
    .in_right     (in_right),
    .frame_mode   (frame_mode),
    .direct_delay (direct_delay),
    .frame_delay  (frame_delay),
    .out_vld      (out_vld),
    .out_left     (out_left),
    .out_right    (out_right)
  );

  function automatic string row_tag(int i);
    case (i)
      0:       return "R1";
      1:       return "R2";
      2:       return "R6";
      3:       return "R8";
      4:       return "R4";
      5:       return "R4";
      6:       return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [2*SW-1:0] act, logic [2*SW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_delay();
    if (frame_mode) return (int'(frame_delay) > MAXD) ? MAXD : int'(frame_delay);
    return int'(direct_delay);
  endfunction

  task automatic strobe(string tag);
    logic [SW-1:0]   l, r;
    logic [2*SW-1:0] exp;
    logic [2*SW-1:0] held;
    int d;
    l = SW'(seq * 3 + 1);
    r = SW'(seq * 5 + 'h800000);
    seq++;
    @(negedge clk);
    in_vld = 1'b1; in_left = l; in_right = r;
    d = eff_delay();
    hist[k % DEPTH] = {l, r};
    exp = (d <= k) ? hist[(k - d) % DEPTH] : '0;
    k++;
    @(negedge clk);
    in_vld = 1'b0;
    check("R8 vld", {47'd0, out_vld}, 48'd1);
    check(tag, {out_left, out_right}, exp);
    held = {out_left, out_right};
    @(negedge clk);
    check("R8 hold", {out_vld, out_left, out_right} , {1'b0, held});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    k = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_left = '0; in_right = '0;
    frame_mode = 1'b0; direct_delay = '0; frame_delay = '0;
    repeat (2) @(negedge clk);
    check("R9 in reset", {out_vld, out_left, out_right}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after reset", {out_vld, out_left, out_right}, '0);

    for (int i = 0; i < 8; i++) begin
      frame_mode   = ROWS[i].mode;
      direct_delay = ROWS[i].direct;
      frame_delay  = ROWS[i].frame;
      for (int j = 0; j < int'(ROWS[i].cnt); j++) strobe(row_tag(i));
    end

    // R8: delay inputs moving between strobes leave the held output alone
    begin
      logic [2*SW-1:0] held;
      held = {out_left, out_right};
      frame_mode = 1'b0; direct_delay = 12'd2;
      @(negedge clk);
      direct_delay = 12'd0;
      @(negedge clk);
      check("R8 no glitch", {out_vld, out_left, out_right}, {1'b0, held});
    end

    // R7 / R3 / R10: maximum delay after a fresh reset, across a buffer wrap
    do_reset();
    check("R9 second reset", {out_vld, out_left, out_right}, '0);
    frame_mode = 1'b0; direct_delay = 12'd4095; frame_delay = 16'd1;
    for (int j = 0; j < 4200; j++) begin
      if (k < MAXD)       strobe("R7");
      else if (k == MAXD) strobe("R3");
      else                strobe("R10");
    end

    // R5: oversized frame counts are limited to the maximum delay
    frame_mode = 1'b1; direct_delay = 12'd3; frame_delay = 16'hFFFF;
    for (int j = 0; j < 10; j++) strobe("R5");
    frame_delay = 16'd4096;
    for (int j = 0; j < 5; j++) strobe("R5");
    frame_mode = 1'b0; direct_delay = 12'd0;
    for (int j = 0; j < 3; j++) strobe("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule